// File: doc/BRIEF.md
# Debounced Line-Edge Interrupt Counter

This block raises an interrupt after a programmed number of rising edges on one watched video address line. Software sets the count with a single register write. The same write drops any interrupt that is already pending. Each edge that passes the filter adds one to the count. When the count reaches a threshold, the interrupt goes pending and the count returns to zero.

The edge filter rejects short pulses. An edge counts only when the line has been low for a minimum number of CPU-cycle ticks before it rises. Loading zero works as the disable: the counter never advances from zero. Each interrupt also leaves the counter at zero, so counting stops until software reloads it.

All pins are plain control and status signals, with no data stream. Back-pressure therefore does not apply: a write is taken in the cycle its strobe is high, and the interrupt is a level output.

Top module: `edge_line_irq`

## Requirements
- R1: A write whose address, ANDed with 0xF003, equals 0xF000 loads the counter with the 8-bit data and clears the pending interrupt, whatever the data value. The interrupt is low in the cycle after the write.
- R2: A write whose masked address differs from 0xF000 (for example 0xF001, 0xE000 or 0x7000) changes neither the counter nor the interrupt. Addresses that alias after masking (for example 0xF004) act as the load register.
- R3: On each accepted edge, a non-zero counter increments by one. If the result is 240 or more, the interrupt goes pending and the counter becomes 0. Otherwise the counter holds the result.
- R4: While the counter is 0, accepted edges leave it at 0, so loading 0 disables the interrupt.
- R5: A rising edge of the watched line is accepted only if, while the line was low, at least 3 CPU-cycle ticks were seen. With only 2 ticks the edge is ignored. The low-tick count saturates and clears whenever the line is seen high.
- R6: A load of 239 fires on the first accepted edge, a load of 255 fires on the first accepted edge, and a load of 1 fires on the 239th accepted edge and not before.
- R7: Reset clears the counter, the pending interrupt and the edge filter. An edge right after reset is not accepted and does not count.
- R8: The pending interrupt stays high until a load write or reset. Further edges leave it set.
- R9: If a load write and an accepted edge fall in the same cycle, the load wins: the counter takes the written value and the interrupt is not raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One-cycle pulse per CPU cycle |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| vline | input | 1 | Watched video address line |
| irq | output | 1 | Active-high interrupt request |

## Verification
The counter is loaded from several starting points: 1, 200, 239, 240 and 255. The interrupt must rise on exactly the edge the threshold rule predicts. This separates an off-by-one in the compare from a wrong increment and from a missing wrap.

Edges are driven with 2 and with 3 low ticks, which places the filter boundary exactly. A load of zero followed by many edges tells the disable apart from ordinary counting. Writes to non-matching and aliasing addresses, a load that lands on the same cycle as an edge, and a reset while the interrupt is pending each check one ordering rule.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int DEF_ADDR_W  = 16;
  localparam int DEF_DATA_W  = 8;
  localparam int DEF_LOW_MIN = 3;
  localparam int DEF_THRESH  = 240;
  localparam logic [15:0] DEF_LOAD_MASK  = 16'hF003;
  localparam logic [15:0] DEF_LOAD_MATCH = 16'hF000;

  function automatic int cnt_width(input int max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/elq_low_filter.sv
module elq_low_filter #(
  parameter int LOW_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_tick,
  input  logic line_i,
  output logic accept_o
);
  localparam int LW = edge_irq_pkg::cnt_width(LOW_MIN);
  localparam logic [LW-1:0] LOW_TOP = LW'(LOW_MIN);

  logic          prev_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      low_q  <= '0;
    end else begin
      prev_q <= line_i;
      if (line_i)
        low_q <= '0;
      else if (cpu_tick && (low_q < LOW_TOP))
        low_q <= low_q + 1'b1;
    end
  end

  assign accept_o = line_i && !prev_q && (low_q >= LOW_TOP);
endmodule

// File: rtl/elq_decode.sv
module elq_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK  = 16'hF003,
  parameter logic [ADDR_W-1:0] MATCH = 16'hF000
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              load_o
);
  assign load_o = wr_en && ((wr_addr & MASK) == MATCH);
endmodule

// File: rtl/elq_count_core.sv
module elq_count_core #(
  parameter int DATA_W = 8,
  parameter int THRESH = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] count_o,
  output logic              pend_o
);
  localparam int SW = DATA_W + 1;
  localparam logic [SW-1:0] LIMIT = SW'(THRESH);

  logic [DATA_W-1:0] cnt_q;
  logic              pend_q;
  logic [SW-1:0]     next_sum;

  assign next_sum = {1'b0, cnt_q} + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      pend_q <= 1'b0;
    end else if (step_i && (cnt_q != '0)) begin
      if (next_sum >= LIMIT) begin
        cnt_q  <= '0;
        pend_q <= 1'b1;
      end else begin
        cnt_q <= next_sum[DATA_W-1:0];
      end
    end
  end

  assign count_o = cnt_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/edge_line_irq.sv
module edge_line_irq #(
  parameter int ADDR_W  = edge_irq_pkg::DEF_ADDR_W,
  parameter int DATA_W  = edge_irq_pkg::DEF_DATA_W,
  parameter int LOW_MIN = edge_irq_pkg::DEF_LOW_MIN,
  parameter int THRESH  = edge_irq_pkg::DEF_THRESH,
  parameter logic [ADDR_W-1:0] LOAD_MASK  = edge_irq_pkg::DEF_LOAD_MASK,
  parameter logic [ADDR_W-1:0] LOAD_MATCH = edge_irq_pkg::DEF_LOAD_MATCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vline,
  output logic              irq
);
  logic              load_hit;
  logic              accept_pulse;
  logic [DATA_W-1:0] count_q;

  elq_decode #(.ADDR_W(ADDR_W), .MASK(LOAD_MASK), .MATCH(LOAD_MATCH)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .load_o (load_hit)
  );

  elq_low_filter #(.LOW_MIN(LOW_MIN)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_tick(cpu_tick),
    .line_i  (vline),
    .accept_o(accept_pulse)
  );

  elq_count_core #(.DATA_W(DATA_W), .THRESH(THRESH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_hit),
    .load_val_i(wr_data),
    .step_i    (accept_pulse),
    .count_o   (count_q),
    .pend_o    (irq)
  );
endmodule

// File: rtl/edge_line_irq_chk.sv
module edge_line_irq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vline,
  input logic              load_hit,
  input logic              accept_pulse,
  input logic [DATA_W-1:0] count_q,
  input logic              irq
);
  p_load_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> !irq);
  p_fire_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (count_q == '0));
  p_rise_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(accept_pulse));
  p_zero_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !load_hit) |=> (count_q == '0));
  p_edge_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_pulse |-> !$past(vline));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !load_hit) |=> irq);
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && accept_pulse) |=> (!irq && count_q == $past(count_q) + 0 || !irq));
endmodule

bind edge_line_irq edge_line_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vline       (vline),
  .load_hit    (load_hit),
  .accept_pulse(accept_pulse),
  .count_q     (count_q),
  .irq         (irq)
);

// File: tb/sim_edge_line_irq.sv
module sim_edge_line_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        vline = 1'b1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string tag; } exp_t;
  exp_t sb[$];

  int m_cnt = 0;
  bit m_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_line_irq u0 (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .vline(vline), .irq(irq)
  );

  // monitor: compare queued expectations against irq away from the clock edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (irq !== e.exp) begin
        n_bad++;
        $display("FAIL %s irq actual=%0b expected=%0b", e.tag, irq, e.exp);
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.exp = m_pend;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic model_load(input logic [15:0] a, input logic [7:0] d);
    if ((a & 16'hF003) == 16'hF000) begin
      m_cnt  = d;
      m_pend = 1'b0;
    end
  endtask

  task automatic model_step();
    if (m_cnt != 0) begin
      if (m_cnt + 1 >= 240) begin
        m_cnt  = 0;
        m_pend = 1'b1;
      end else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_load(a, d);
    expect_now(tag);
  endtask

  // low for n ticks, then rise; optional write landing on the rising cycle
  task automatic line_pulse(input int n, input bit with_load, input logic [7:0] d,
                            input string tag);
    @(negedge clk);
    vline = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_tick = 1'b1;
    end
    @(negedge clk);
    cpu_tick = 1'b0;
    vline = 1'b1;
    if (with_load) begin
      wr_en = 1'b1; wr_addr = 16'hF000; wr_data = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (with_load) model_load(16'hF000, d);
    else if (n >= 3) model_step();
    expect_now(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now("R7 reset state");

    // R6 / R3: load 239 fires on first edge
    cpu_write(16'hF000, 8'd239, "R1 load 239");
    line_pulse(3, 1'b0, 8'd0, "R6 239 fires first edge");
    // R8: extra edges keep it pending
    line_pulse(3, 1'b0, 8'd0, "R8 sticky after edge");
    line_pulse(4, 1'b0, 8'd0, "R8 sticky after second edge");
    // R2: non-matching writes ignored
    cpu_write(16'hF001, 8'd5, "R2 F001 ignored");
    cpu_write(16'hE000, 8'd5, "R2 E000 ignored");
    cpu_write(16'h7000, 8'd5, "R2 7000 ignored");
    // R2 alias clears
    cpu_write(16'hF004, 8'h55, "R2 alias F004 loads");

    // R5 filter boundary
    cpu_write(16'hF000, 8'd239, "R1 load again");
    line_pulse(2, 1'b0, 8'd0, "R5 two ticks rejected");
    line_pulse(3, 1'b0, 8'd0, "R5 three ticks accepted");
    cpu_write(16'hF000, 8'd0, "R1 clears pending with zero");

    // R4 zero disables
    cpu_write(16'hF000, 8'd100, "R4 load 100");
    cpu_write(16'hF000, 8'd0, "R4 load 0");
    for (int i = 0; i < 250; i++) line_pulse(3, 1'b0, 8'd0, "R4 no count at zero");

    // R6 load 1 fires on 239th edge
    cpu_write(16'hF000, 8'd1, "R6 load 1");
    for (int i = 0; i < 238; i++) line_pulse(3, 1'b0, 8'd0, "R6 not yet fired");
    line_pulse(3, 1'b0, 8'd0, "R6 fires on 239th edge");

    // R3 from 200: 39 quiet, 40th fires
    cpu_write(16'hF000, 8'd200, "R3 load 200");
    for (int i = 0; i < 39; i++) line_pulse(3, 1'b0, 8'd0, "R3 below threshold");
    line_pulse(3, 1'b0, 8'd0, "R3 fires at 240");

    // R6 255 and R3 240 fire immediately
    cpu_write(16'hF000, 8'd255, "R6 load 255");
    line_pulse(3, 1'b0, 8'd0, "R6 255 fires first edge");
    cpu_write(16'hF000, 8'd240, "R3 load 240");
    line_pulse(3, 1'b0, 8'd0, "R3 240 fires first edge");

    // R9 load wins over simultaneous edge
    cpu_write(16'hF000, 8'd239, "R9 preload 239");
    line_pulse(3, 1'b1, 8'd239, "R9 load beats edge");
    line_pulse(3, 1'b0, 8'd0, "R9 reloaded value fires next edge");

    // R7 reset while pending, then edge does not count
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_pend = 1'b0;
    expect_now("R7 reset clears pending");
    line_pulse(3, 1'b0, 8'd0, "R7 counter cleared by reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule